// File: doc/BRIEF.md
# UART Modem Control and Local Loopback Stage

This block holds the modem-control byte of one serial channel and turns it into the channel's active-low handshake outputs and mode selects. The host writes the byte over a simple register strobe. Bits 4 to 0 can always be written. Bits 7 to 5 are guarded by an enhanced-feature enable input. The byte selects a divide-by-4 clock prescale and enables access to the transmit-control and trigger-level registers. It also enables the Xon-any behaviour and the FIFO-ready register, and it drives RTS, DTR and a general-purpose output.

When local loopback is on, the transmit serial stream returns to the receiver internally. The external pins are parked at their idle HIGH level. The upper nibble of the modem status register then takes its values from control bits instead of from the external modem inputs.

The status register has a lower nibble of delta flags. A flag is set whenever its status bit changes, whatever the source of the change. All flags clear when the host reads the status register.

Top module: `uart_mdm_ctl`

## Requirements
- R1: After reset the control byte is 0x00, the status byte is 0x00, and rts_n, dtr_n, gpo_n and tx_pin are HIGH with loopback off.
- R2: A write always loads control bits [4:0] from wr_data, and the new value is visible on ctl_q after the write edge.
- R3: Control bits [7:5] take the written value only when efr_en is 1 during the write; otherwise they keep their old value.
- R4: presc_div4 follows bit 7 (1 means divide-by-4), tcr_access follows bit 6, xon_any follows bit 5, fifo_rdy_en follows bit 2 and loop_mode follows bit 4.
- R5: Outside loopback, rts_n is the inverse of bit 1, dtr_n is the inverse of bit 0 and gpo_n is the inverse of bit 3.
- R6: Outside loopback, while auto_rts_en is 1, rts_n is the inverse of flow_rts and bit 1 has no effect on it.
- R7: In loopback, rx_ser equals tx_ser, rx_pin has no effect, and tx_pin, rts_n, dtr_n and gpo_n are all HIGH.
- R8: Outside loopback, rx_ser equals rx_pin and tx_pin equals tx_ser. One clock after the inputs are sampled, status bits [7:4] equal the inverted {cd_n, ri_n, dsr_n, cts_n}.
- R9: In loopback, status bit 4 takes control bit 1, bit 5 takes bit 0, bit 6 takes bit 2 and bit 7 takes bit 3, one clock after the control byte.
- R10: Status bit k (k = 0..3) is set in the same update in which status bit k+4 changes, and it stays set until a read.
- R11: A cycle with reg_rd at 1 clears all delta flags at the next edge. A status bit that changes at that same edge leaves its delta flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe for the status byte (clears deltas) |
| efr_en | input | 1 | Enhanced-feature enable, unlocks bits [7:5] |
| auto_rts_en | input | 1 | Hardware flow control owns RTS |
| flow_rts | input | 1 | Flow-control RTS request, 1 = assert |
| tx_ser | input | 1 | Serial data from the transmitter |
| rx_pin | input | 1 | External receive pin |
| cts_n | input | 1 | External clear-to-send, active low |
| dsr_n | input | 1 | External data-set-ready, active low |
| ri_n | input | 1 | External ring indicator, active low |
| cd_n | input | 1 | External carrier detect, active low |
| tx_pin | output | 1 | External transmit pin |
| rx_ser | output | 1 | Serial data to the receiver |
| rts_n | output | 1 | RTS pin, active low |
| dtr_n | output | 1 | DTR pin, active low |
| gpo_n | output | 1 | General-purpose output, active low |
| presc_div4 | output | 1 | Clock prescale select, 1 = divide-by-4 |
| tcr_access | output | 1 | Access enable for transmit-control/trigger registers |
| xon_any | output | 1 | Xon-any enable to flow control |
| fifo_rdy_en | output | 1 | FIFO-ready register enable |
| loop_mode | output | 1 | Local loopback active |
| ctl_q | output | 8 | Control byte |
| msr_q | output | 8 | Modem status byte |

## Verification
The control byte is written with walking patterns and with complementary bytes, first with the enhanced enable low and then high. This separates the protected upper bits from the always-writable lower ones. The status path is driven once from distinct external pin patterns and once from loopback control bytes with single bits set, so a swap in the loopback routing shows up as a wrong bit position. The delta logic is tried with a change on its own, a plain read, and a read that lands on the same edge as a change, which shows whether set or clear takes priority.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
   localparam int CTL_W      = 8;
   localparam int MDM_N      = 4;
   // control bit positions
   localparam int B_DTR      = 0;
   localparam int B_RTS      = 1;
   localparam int B_FRDY     = 2;
   localparam int B_GPO      = 3;
   localparam int B_LOOP     = 4;
   localparam int B_XANY     = 5;
   localparam int B_TACC     = 6;
   localparam int B_DIV4     = 7;
   localparam int PROT_LSB   = 5;

   typedef struct packed {
      logic cd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_in_t;

   function automatic mdm_in_t loop_route(input logic [CTL_W-1:0] c);
      mdm_in_t m;
      m.cts = c[B_RTS];
      m.dsr = c[B_DTR];
      m.ri  = c[B_FRDY];
      m.cd  = c[B_GPO];
      return m;
   endfunction
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
   import uart_mdm_pkg::*;
#(
   parameter int W       = CTL_W,
   parameter int LOCK_LO = PROT_LSB
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         unlock,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] LOCK_MASK = ~((W'(1) << LOCK_LO) - W'(1));

   initial begin
      if (LOCK_LO < 1 || LOCK_LO >= W) $error("mdm_ctl_reg: LOCK_LO out of range");
   end

   logic [W-1:0] wmask;
   assign wmask = unlock ? {W{1'b1}} : ~LOCK_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= (q & ~wmask) | (wdata & wmask);
   end

   // R3
   upper_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !unlock) |=> ((q & LOCK_MASK) == ($past(q) & LOCK_MASK)));
   // R2
   lower_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((q & ~LOCK_MASK) == ($past(wdata) & ~LOCK_MASK)));
endmodule

// File: rtl/mdm_pin_drv.sv
module mdm_pin_drv
   import uart_mdm_pkg::*;
#(
   parameter bit HAS_AUTO_RTS = 1'b1
) (
   input  logic [CTL_W-1:0] ctl,
   input  logic             auto_rts_en,
   input  logic             flow_rts,
   input  logic             tx_ser,
   input  logic             rx_pin,
   output logic             tx_pin,
   output logic             rx_ser,
   output logic             rts_n,
   output logic             dtr_n,
   output logic             gpo_n
);
   logic lp;
   logic rts_req;
   assign lp = ctl[B_LOOP];

   generate
      if (HAS_AUTO_RTS) begin : g_auto
         assign rts_req = auto_rts_en ? flow_rts : ctl[B_RTS];
      end else begin : g_manual
         logic unused_auto;
         assign unused_auto = auto_rts_en ^ flow_rts;
         assign rts_req = ctl[B_RTS];
      end
   endgenerate

   assign rts_n  = lp ? 1'b1 : ~rts_req;
   assign dtr_n  = lp ? 1'b1 : ~ctl[B_DTR];
   assign gpo_n  = lp ? 1'b1 : ~ctl[B_GPO];
   assign tx_pin = lp ? 1'b1 : tx_ser;
   assign rx_ser = lp ? tx_ser : rx_pin;

   // R7
   always_comb begin
      loop_idle_chk: assert (!lp || (rts_n && dtr_n && gpo_n && tx_pin && (rx_ser == tx_ser)));
   end
endmodule

// File: rtl/mdm_stat_trk.sv
module mdm_stat_trk
   import uart_mdm_pkg::*;
#(
   parameter int N = MDM_N
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   src,
   input  logic           rd,
   output logic [2*N-1:0] stat
);
   logic [N-1:0] lvl_q;
   logic [N-1:0] dlt_q;

   initial begin
      if (N < 1) $error("mdm_stat_trk: N must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= src;
   end

   generate
      for (genvar k = 0; k < N; k++) begin : g_dlt
         logic chg;
         assign chg = src[k] ^ lvl_q[k];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   dlt_q[k] <= 1'b0;
            else if (chg) dlt_q[k] <= 1'b1;
            else if (rd)  dlt_q[k] <= 1'b0;
         end
         // R10
         dlt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (lvl_q[k] != $past(lvl_q[k]))) |-> dlt_q[k]);
         // R11
         dlt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rd) && (lvl_q[k] == $past(lvl_q[k]))) |-> !dlt_q[k]);
      end
   endgenerate

   assign stat = {lvl_q, dlt_q};
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
   import uart_mdm_pkg::*;
#(
   parameter bit HAS_AUTO_RTS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] wr_data,
   input  logic       reg_rd,
   input  logic       efr_en,
   input  logic       auto_rts_en,
   input  logic       flow_rts,
   input  logic       tx_ser,
   input  logic       rx_pin,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       ri_n,
   input  logic       cd_n,
   output logic       tx_pin,
   output logic       rx_ser,
   output logic       rts_n,
   output logic       dtr_n,
   output logic       gpo_n,
   output logic       presc_div4,
   output logic       tcr_access,
   output logic       xon_any,
   output logic       fifo_rdy_en,
   output logic       loop_mode,
   output logic [7:0] ctl_q,
   output logic [7:0] msr_q
);
   initial begin
      if (CTL_W != 8) $error("uart_mdm_ctl: control byte must be 8 bits");
      if (2*MDM_N != 8) $error("uart_mdm_ctl: status byte must be 8 bits");
   end

   logic [CTL_W-1:0] ctl;
   mdm_in_t          ext_in;
   mdm_in_t          sel_in;

   mdm_ctl_reg #(.W(CTL_W), .LOCK_LO(PROT_LSB)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(wr_data),
      .unlock(efr_en), .q(ctl));

   mdm_pin_drv #(.HAS_AUTO_RTS(HAS_AUTO_RTS)) u_drv (
      .ctl(ctl), .auto_rts_en(auto_rts_en), .flow_rts(flow_rts),
      .tx_ser(tx_ser), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_ser(rx_ser),
      .rts_n(rts_n), .dtr_n(dtr_n), .gpo_n(gpo_n));

   assign ext_in.cts = ~cts_n;
   assign ext_in.dsr = ~dsr_n;
   assign ext_in.ri  = ~ri_n;
   assign ext_in.cd  = ~cd_n;
   assign sel_in = ctl[B_LOOP] ? loop_route(ctl) : ext_in;

   mdm_stat_trk #(.N(MDM_N)) u_stat (
      .clk(clk), .rst_n(rst_n), .src(sel_in), .rd(reg_rd), .stat(msr_q));

   assign ctl_q       = ctl;
   assign presc_div4  = ctl[B_DIV4];
   assign tcr_access  = ctl[B_TACC];
   assign xon_any     = ctl[B_XANY];
   assign fifo_rdy_en = ctl[B_FRDY];
   assign loop_mode   = ctl[B_LOOP];

   // R8
   ext_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ctl[B_LOOP])) |->
         (msr_q[7:4] == ~$past({cd_n, ri_n, dsr_n, cts_n})));
   // R9
   loop_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl[B_LOOP])) |->
         (msr_q[7:4] == $past({ctl[B_GPO], ctl[B_FRDY], ctl[B_DTR], ctl[B_RTS]})));
endmodule

// File: tb/sim_uart_mdm_ctl.sv
module sim_uart_mdm_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 0, reg_rd = 0, efr_en = 0, auto_rts_en = 0, flow_rts = 0;
   logic [7:0] wr_data = 8'h00;
   logic tx_ser = 1, rx_pin = 1, cts_n = 1, dsr_n = 1, ri_n = 1, cd_n = 1;
   logic tx_pin, rx_ser, rts_n, dtr_n, gpo_n, presc_div4, tcr_access, xon_any, fifo_rdy_en, loop_mode;
   logic [7:0] ctl_q, msr_q;
   int total = 0, bad = 0;
   logic [7:0] mdl = 8'h00;

   always #4 clk = ~clk;

   uart_mdm_ctl u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic en);
      reg_wr = 1; wr_data = d; efr_en = en;
      @(negedge clk);
      reg_wr = 0; efr_en = 0;
      mdl = en ? d : {mdl[7:5], d[4:0]};
   endtask

   task automatic rd_clr();
      reg_rd = 1;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 ctl", ctl_q, 8'h00);
      chk("R1 msr", msr_q, 8'h00);
      chk("R1 pins", {rts_n, dtr_n, gpo_n, tx_pin, loop_mode}, 5'b11110);
   endtask

   task automatic t_lock();
      wr(8'hE5, 1'b0);
      chk("R2 lower", ctl_q, 8'h05);
      chk("R3 locked", ctl_q[7:5], 3'b000);
      wr(8'hA3, 1'b1);
      chk("R3 unlocked", ctl_q, 8'hA3);
      wr(8'h4C, 1'b0);
      chk("R3 held", ctl_q, 8'hAC);
      chk("R2 model", ctl_q, mdl);
   endtask

   task automatic t_fields();
      wr(8'hC4, 1'b1);
      chk("R4 c4", {presc_div4, tcr_access, xon_any, fifo_rdy_en, loop_mode}, 5'b11010);
      wr(8'h20, 1'b1);
      chk("R4 20", {presc_div4, tcr_access, xon_any, fifo_rdy_en, loop_mode}, 5'b00100);
   endtask

   task automatic t_polarity();
      wr(8'h0A, 1'b1);
      chk("R5 0a", {rts_n, dtr_n, gpo_n}, 3'b010);
      wr(8'h01, 1'b1);
      chk("R5 01", {rts_n, dtr_n, gpo_n}, 3'b101);
   endtask

   task automatic t_auto_rts();
      wr(8'h02, 1'b1);
      auto_rts_en = 1; flow_rts = 0; #1;
      chk("R6 flow0", rts_n, 1'b1);
      flow_rts = 1; #1;
      chk("R6 flow1", rts_n, 1'b0);
      wr(8'h00, 1'b1);
      chk("R6 bit ignored", rts_n, 1'b0);
      auto_rts_en = 0; flow_rts = 0; #1;
      chk("R6 off", rts_n, 1'b1);
   endtask

   task automatic t_paths();
      wr(8'h00, 1'b1);
      tx_ser = 0; rx_pin = 1; #1;
      chk("R8 normal paths", {tx_pin, rx_ser}, 2'b01);
      wr(8'h1F, 1'b1);
      chk("R7 loop pins", {rts_n, dtr_n, gpo_n, tx_pin}, 4'b1111);
      chk("R7 rx from tx", rx_ser, 1'b0);
      rx_pin = 0; tx_ser = 1; #1;
      chk("R7 rx_pin ignored", rx_ser, 1'b1);
      rx_pin = 1;
   endtask

   task automatic t_ext_status();
      wr(8'h00, 1'b1);
      @(negedge clk); rd_clr();
      cts_n = 0; dsr_n = 1; ri_n = 1; cd_n = 0;
      @(negedge clk);
      chk("R8 status 9", msr_q[7:4], 4'b1001);
      chk("R10 deltas", msr_q[3:0], 4'b1001);
      cts_n = 1; dsr_n = 0; ri_n = 0; cd_n = 0;
      @(negedge clk);
      chk("R8 status e", msr_q[7:4], 4'b1110);
      chk("R10 held", msr_q[3:0], 4'b1111);
      rd_clr();
      chk("R11 cleared", msr_q[3:0], 4'b0000);
      cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1;
      @(negedge clk); rd_clr();
   endtask

   task automatic t_loop_status();
      logic [3:0] exp;
      for (int b = 0; b < 4; b++) begin
         wr(8'h10 | (8'h01 << b), 1'b1);
         @(negedge clk);
         exp = 4'b0000;
         case (b)
            0: exp = 4'b0010;
            1: exp = 4'b0001;
            2: exp = 4'b0100;
            default: exp = 4'b1000;
         endcase
         chk("R9 loop route", msr_q[7:4], exp);
      end
      cts_n = 0; #1;
      @(negedge clk);
      chk("R9 ext ignored", msr_q[7:4], 4'b1000);
      cts_n = 1;
      rd_clr();
   endtask

   task automatic t_race();
      wr(8'h10, 1'b1);
      @(negedge clk); rd_clr();
      chk("R10 clean", msr_q[3:0], 4'b0000);
      wr(8'h12, 1'b1);
      reg_rd = 1;
      @(negedge clk);
      reg_rd = 0;
      chk("R11 set wins", msr_q[3:0], 4'b0001);
      rd_clr();
      chk("R11 later clear", msr_q[3:0], 4'b0000);
   endtask

   initial begin
      #2000000;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_fields();
      t_polarity();
      t_auto_rts();
      t_paths();
      t_ext_status();
      t_loop_status();
      t_race();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule